// File: doc/BRIEF.md
# Thread-Clustering Memory Request Scheduler

This block is the request arbiter of a DRAM controller shared by several hardware threads. At every quantum boundary it looks at how many memory misses each thread produced in the quantum just ended. It sorts the threads from lightest to heaviest and splits them into two groups. Threads that together account for only a small share of the misses form a latency-sensitive group. Every remaining thread belongs to a bandwidth-heavy group. The software-visible threshold that sets the split is a fraction of the total misses.

Every cycle the block chooses one entry from the controller's request buffer and presents its index as a grant. The choice looks at the group first: any light-thread request wins over any heavy-thread request. Inside the light group, lighter threads win. Inside the heavy group the order is rotated by one position each time a programmable number of cycles passes, so that no heavy thread stays at the bottom for long. When two requests have the same group and rank, a hit to the row that is open in the target bank wins. After that the older request wins, and then the lower buffer slot. The grant is formed combinationally. The block keeps a registered copy of the index that was last accepted through the take handshake.

Top module: `tcms_sched`

## Requirements
- R1: After reset, before any quantum tick, every thread is in the light group and has rank equal to its thread ID (lower ID wins), and `gnt_last_o` is 0.
- R2: `gnt_valid_o` is high exactly when at least one bit of `req_valid_i` is set. In that case `gnt_idx_o` names a slot whose valid bit is set.
- R3: When any valid request belongs to a light-group thread, the granted request belongs to a light-group thread, whatever the row hit and age of the other requests.
- R4: Inside the light group, the thread that comes earlier in the sorted order wins. The order is ascending miss count, with equal counts broken by lower thread ID.
- R5: On the clock edge where `quantum_tick_i` is high, the miss counts (thread t in bits [16t+15:16t]) are classified. A thread is light when the sum of its own count and the counts of all threads before it in the sorted order, times 256, is at most `clus_frac_i` times the total. A total of zero therefore makes every thread light. The new classification takes effect in the cycle after that edge.
- R6: Between requests of equal group and rank, a request whose row (slot i: row bits [14i+13:14i], bank bits [3i+2:3i]) equals `open_row_i` of its bank (bits [14b+13:14b]), with `open_valid_i[b]` set, wins over one that does not.
- R7: Remaining ties go to the larger `req_age_i` value (slot i: bits [8i+7:8i]), and then to the lower slot index.
- R8: The heavy thread at heavy position h (its sorted position minus the light count) has rank (h + off) mod (number of heavy threads). `off` becomes 0 on a quantum tick and grows by one, with wrap-around, each time `shuf_period_i` cycles have passed since the tick or since the last step.
- R9: At a clock edge where `gnt_valid_o` and `gnt_take_i` are both high, `gnt_last_o` takes the value of `gnt_idx_o`. At every other edge it holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| quantum_tick_i | input | 1 | Quantum boundary; reclassifies threads |
| miss_cnt_i | input | 128 | Per-thread miss counts of the last quantum, 16 bits each |
| clus_frac_i | input | 8 | Light-group share threshold in 1/256 units |
| shuf_period_i | input | 16 | Cycles between heavy-rank rotations (0 stops rotation) |
| req_valid_i | input | 16 | Slot occupied |
| req_tid_i | input | 48 | Thread ID per slot, 3 bits each |
| req_bank_i | input | 48 | Bank per slot, 3 bits each |
| req_row_i | input | 224 | Row per slot, 14 bits each |
| req_age_i | input | 128 | Age per slot, 8 bits each, larger is older |
| open_valid_i | input | 8 | Bank has an open row |
| open_row_i | input | 112 | Open row per bank, 14 bits each |
| gnt_take_i | input | 1 | Consumer accepts the current grant |
| gnt_valid_o | output | 1 | A grant is offered |
| gnt_idx_o | output | 4 | Slot index of the grant |
| gnt_last_o | output | 4 | Registered index of the last accepted grant |

## Verification
The grant responds to request and open-row changes in the same cycle. The bench therefore drives these inputs at the falling edge and samples one time unit later, before any rising edge. A new classification comes from the edge where the tick is sampled. Checks made just before that edge still see the old ranks, and checks made at the next falling edge see the new ones. A rotation of the heavy ranks lands exactly `shuf_period_i` rising edges after the tick, so the bench samples one edge before that point and again right after it. `gnt_last_o` changes one edge after the take, and it is sampled at the following falling edge.

// File: rtl/tcms_pkg.sv
package tcms_pkg;
  localparam int RANKW = 3;

  typedef struct packed {
    logic             heavy;
    logic [RANKW-1:0] rank;
  } tkey_t;

  // thread u sorts before thread t: fewer misses, or equal misses and lower ID
  function automatic logic sorts_before(input logic [31:0] mu, input int u,
                                        input logic [31:0] mt, input int t);
    return (mu < mt) || ((mu == mt) && (u < t));
  endfunction

  // rotate a heavy position by the shuffle offset within n heavy slots
  function automatic logic [4:0] rotate_pos(input logic [4:0] h, input logic [4:0] off,
                                            input logic [4:0] n);
    logic [4:0] s;
    s = h + off;
    if (s >= n) s = s - n;
    return s;
  endfunction
endpackage

// File: rtl/tcms_cluster.sv
module tcms_cluster
  import tcms_pkg::*;
#(
  parameter int NTHR  = 8,
  parameter int MISSW = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     tick_i,
  input  logic [NTHR*MISSW-1:0]    miss_flat_i,
  input  logic [7:0]               frac_i,
  input  logic [$clog2(NTHR+1)-1:0] off_i,
  output tkey_t                    key_o [NTHR],
  output logic [$clog2(NTHR+1)-1:0] nheavy_o
);
  localparam int TIDW = (NTHR > 1) ? $clog2(NTHR) : 1;
  localparam int CNTW = $clog2(NTHR+1);
  localparam int SUMW = MISSW + $clog2(NTHR) + 1;
  localparam int PRDW = SUMW + 8;

  logic [MISSW-1:0] m [NTHR];
  logic [TIDW-1:0]  pos_n [NTHR];
  logic [SUMW-1:0]  pre_n [NTHR];
  logic [SUMW-1:0]  total;
  logic [NTHR-1:0]  light_n;
  logic [CNTW-1:0]  nlight_n;

  logic [TIDW-1:0]  pos_q [NTHR];
  logic [NTHR-1:0]  light_q;
  logic [CNTW-1:0]  nlight_q;

  always_comb begin
    for (int t = 0; t < NTHR; t++) m[t] = miss_flat_i[t*MISSW +: MISSW];
  end

  always_comb begin
    total = '0;
    for (int u = 0; u < NTHR; u++) total = total + SUMW'(m[u]);
    nlight_n = '0;
    for (int t = 0; t < NTHR; t++) begin
      pos_n[t] = '0;
      pre_n[t] = SUMW'(m[t]);
      for (int u = 0; u < NTHR; u++) begin
        if (u != t && sorts_before(32'(m[u]), u, 32'(m[t]), t)) begin
          pos_n[t] = pos_n[t] + 1'b1;
          pre_n[t] = pre_n[t] + SUMW'(m[u]);
        end
      end
      light_n[t] = ({pre_n[t], 8'h00}) <= (PRDW'(frac_i) * PRDW'(total));
      nlight_n   = nlight_n + CNTW'(light_n[t]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int t = 0; t < NTHR; t++) pos_q[t] <= TIDW'(t);
      light_q  <= '1;
      nlight_q <= CNTW'(NTHR);
    end else if (tick_i) begin
      for (int t = 0; t < NTHR; t++) pos_q[t] <= pos_n[t];
      light_q  <= light_n;
      nlight_q <= nlight_n;
    end
  end

  assign nheavy_o = CNTW'(NTHR) - nlight_q;

  always_comb begin
    for (int t = 0; t < NTHR; t++) begin
      if (light_q[t]) begin
        key_o[t].heavy = 1'b0;
        key_o[t].rank  = RANKW'(pos_q[t]);
      end else begin
        key_o[t].heavy = 1'b1;
        key_o[t].rank  = RANKW'(rotate_pos(5'(pos_q[t]) - 5'(nlight_q), 5'(off_i), 5'(nheavy_o)));
      end
    end
  end

  // R5: the light group is always a prefix of the sorted order
  for (genvar g = 0; g < NTHR; g++) begin : g_chk
    a_r5_light_prefix: assert property (@(posedge clk) disable iff (!rst_n)
      light_q[g] == (CNTW'(pos_q[g]) < nlight_q));
  end
endmodule

// File: rtl/tcms_shuffle.sv
module tcms_shuffle #(
  parameter int NTHR = 8,
  parameter int PERW = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      tick_i,
  input  logic [PERW-1:0]           period_i,
  input  logic [$clog2(NTHR+1)-1:0] nheavy_i,
  output logic [$clog2(NTHR+1)-1:0] off_o
);
  localparam int CNTW = $clog2(NTHR+1);

  logic [PERW-1:0] cnt_q;
  logic            step_due;

  assign step_due = (period_i != '0) && (cnt_q >= period_i - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n || tick_i) begin
      cnt_q <= '0;
      off_o <= '0;
    end else if (period_i == '0) begin
      cnt_q <= '0;
    end else if (step_due) begin
      cnt_q <= '0;
      off_o <= (off_o + 1'b1 >= nheavy_i) ? '0 : off_o + 1'b1;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  a_r8_off_range: assert property (@(posedge clk) disable iff (!rst_n)
    (nheavy_i != '0) |-> (off_o < nheavy_i));
  a_r8_off_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !step_due) |=> $stable(off_o));
  a_r8_tick_clear: assert property (@(posedge clk) disable iff (!rst_n)
    tick_i |=> (off_o == '0));
endmodule

// File: rtl/tcms_pick.sv
module tcms_pick
  import tcms_pkg::*;
#(
  parameter int NTHR  = 8,
  parameter int NREQ  = 16,
  parameter int NBANK = 8,
  parameter int ROWW  = 14,
  parameter int AGEW  = 8
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  tkey_t                           key_i [NTHR],
  input  logic [NREQ-1:0]                 valid_i,
  input  logic [NREQ*$clog2(NTHR)-1:0]    tid_i,
  input  logic [NREQ*$clog2(NBANK)-1:0]   bank_i,
  input  logic [NREQ*ROWW-1:0]            row_i,
  input  logic [NREQ*AGEW-1:0]            age_i,
  input  logic [NBANK-1:0]                open_valid_i,
  input  logic [NBANK*ROWW-1:0]           open_row_i,
  output logic                            gnt_valid_o,
  output logic [$clog2(NREQ)-1:0]         gnt_idx_o
);
  localparam int TIDW  = $clog2(NTHR);
  localparam int BANKW = $clog2(NBANK);
  localparam int IDXW  = $clog2(NREQ);
  localparam int SCW   = 1 + RANKW + 1 + AGEW;

  logic [SCW-1:0]  score [NREQ];
  logic [NREQ-1:0] is_light;
  logic [NREQ-1:0] row_hit;
  logic [SCW-1:0]  best_s;
  logic            any_light;
  logic            gnt_light;

  always_comb begin
    for (int i = 0; i < NREQ; i++) begin
      logic [TIDW-1:0]  tid;
      logic [BANKW-1:0] bk;
      tid = tid_i[i*TIDW +: TIDW];
      bk  = bank_i[i*BANKW +: BANKW];
      row_hit[i]  = open_valid_i[bk] && (open_row_i[bk*ROWW +: ROWW] == row_i[i*ROWW +: ROWW]);
      is_light[i] = !key_i[tid].heavy;
      score[i]    = {key_i[tid].heavy, key_i[tid].rank, !row_hit[i], ~age_i[i*AGEW +: AGEW]};
    end
  end

  always_comb begin
    gnt_valid_o = 1'b0;
    gnt_idx_o   = '0;
    best_s      = '1;
    for (int i = 0; i < NREQ; i++) begin
      if (valid_i[i] && (!gnt_valid_o || score[i] < best_s)) begin
        gnt_valid_o = 1'b1;
        gnt_idx_o   = IDXW'(i);
        best_s      = score[i];
      end
    end
  end

  assign any_light = |(valid_i & is_light);
  assign gnt_light = is_light[gnt_idx_o];

  a_r2_grant_slot_valid: assert property (@(posedge clk) disable iff (!rst_n)
    gnt_valid_o |-> valid_i[gnt_idx_o]);
  a_r2_no_lost_request: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i != '0) |-> gnt_valid_o);
  a_r3_light_first: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_valid_o && any_light) |-> gnt_light);
endmodule

// File: rtl/tcms_sched.sv
module tcms_sched
  import tcms_pkg::*;
#(
  parameter int NTHR  = 8,
  parameter int NREQ  = 16,
  parameter int NBANK = 8,
  parameter int ROWW  = 14,
  parameter int AGEW  = 8,
  parameter int MISSW = 16,
  parameter int PERW  = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          quantum_tick_i,
  input  logic [NTHR*MISSW-1:0]         miss_cnt_i,
  input  logic [7:0]                    clus_frac_i,
  input  logic [PERW-1:0]               shuf_period_i,
  input  logic [NREQ-1:0]               req_valid_i,
  input  logic [NREQ*$clog2(NTHR)-1:0]  req_tid_i,
  input  logic [NREQ*$clog2(NBANK)-1:0] req_bank_i,
  input  logic [NREQ*ROWW-1:0]          req_row_i,
  input  logic [NREQ*AGEW-1:0]          req_age_i,
  input  logic [NBANK-1:0]              open_valid_i,
  input  logic [NBANK*ROWW-1:0]         open_row_i,
  input  logic                          gnt_take_i,
  output logic                          gnt_valid_o,
  output logic [$clog2(NREQ)-1:0]       gnt_idx_o,
  output logic [$clog2(NREQ)-1:0]       gnt_last_o
);
  localparam int CNTW = $clog2(NTHR+1);

  tkey_t           keys [NTHR];
  logic [CNTW-1:0] nheavy;
  logic [CNTW-1:0] off;
  logic            accept;

  tcms_cluster #(.NTHR(NTHR), .MISSW(MISSW)) u_cluster (
    .clk(clk), .rst_n(rst_n), .tick_i(quantum_tick_i), .miss_flat_i(miss_cnt_i),
    .frac_i(clus_frac_i), .off_i(off), .key_o(keys), .nheavy_o(nheavy)
  );

  tcms_shuffle #(.NTHR(NTHR), .PERW(PERW)) u_shuffle (
    .clk(clk), .rst_n(rst_n), .tick_i(quantum_tick_i), .period_i(shuf_period_i),
    .nheavy_i(nheavy), .off_o(off)
  );

  tcms_pick #(.NTHR(NTHR), .NREQ(NREQ), .NBANK(NBANK), .ROWW(ROWW), .AGEW(AGEW)) u_pick (
    .clk(clk), .rst_n(rst_n), .key_i(keys), .valid_i(req_valid_i), .tid_i(req_tid_i),
    .bank_i(req_bank_i), .row_i(req_row_i), .age_i(req_age_i),
    .open_valid_i(open_valid_i), .open_row_i(open_row_i),
    .gnt_valid_o(gnt_valid_o), .gnt_idx_o(gnt_idx_o)
  );

  assign accept = gnt_valid_o && gnt_take_i;

  always_ff @(posedge clk) begin
    if (!rst_n)      gnt_last_o <= '0;
    else if (accept) gnt_last_o <= gnt_idx_o;
  end

  a_r9_capture: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (gnt_last_o == $past(gnt_idx_o)));
  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !accept |=> $stable(gnt_last_o));
endmodule

// File: tb/tcms_sched_tb.sv
module tcms_sched_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NTHR = 8, NREQ = 16, NBANK = 8, ROWW = 14, AGEW = 8, MISSW = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic quantum_tick_i = 1'b0;
  logic [NTHR*MISSW-1:0] miss_cnt_i = '0;
  logic [7:0]  clus_frac_i = 8'd128;
  logic [15:0] shuf_period_i = 16'd1000;
  logic [NREQ-1:0] req_valid_i = '0;
  logic [NREQ*3-1:0] req_tid_i = '0;
  logic [NREQ*3-1:0] req_bank_i = '0;
  logic [NREQ*ROWW-1:0] req_row_i = '0;
  logic [NREQ*AGEW-1:0] req_age_i = '0;
  logic [NBANK-1:0] open_valid_i = '0;
  logic [NBANK*ROWW-1:0] open_row_i = '0;
  logic gnt_take_i = 1'b0;
  logic gnt_valid_o;
  logic [3:0] gnt_idx_o, gnt_last_o;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  tcms_sched u_dut (
    .clk(clk), .rst_n(rst_n), .quantum_tick_i(quantum_tick_i), .miss_cnt_i(miss_cnt_i),
    .clus_frac_i(clus_frac_i), .shuf_period_i(shuf_period_i), .req_valid_i(req_valid_i),
    .req_tid_i(req_tid_i), .req_bank_i(req_bank_i), .req_row_i(req_row_i),
    .req_age_i(req_age_i), .open_valid_i(open_valid_i), .open_row_i(open_row_i),
    .gnt_take_i(gnt_take_i), .gnt_valid_o(gnt_valid_o), .gnt_idx_o(gnt_idx_o),
    .gnt_last_o(gnt_last_o)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic clr_reqs();
    req_valid_i = '0; req_tid_i = '0; req_bank_i = '0; req_row_i = '0; req_age_i = '0;
  endtask

  task automatic put(input int s, input int tid, input int bank, input int row, input int age);
    req_valid_i[s] = 1'b1;
    req_tid_i[s*3 +: 3] = 3'(tid);
    req_bank_i[s*3 +: 3] = 3'(bank);
    req_row_i[s*ROWW +: ROWW] = ROWW'(row);
    req_age_i[s*AGEW +: AGEW] = AGEW'(age);
  endtask

  // pair of one-request-per-thread slots; returns granted slot after settle
  task automatic duel(input string req, input int ta, input int tb, input int exp_slot);
    @(negedge clk);
    clr_reqs();
    put(0, ta, 0, 1, 10);
    put(1, tb, 1, 1, 10);
    #1 check(req, int'(gnt_idx_o), exp_slot);
  endtask

  task automatic tick();
    @(negedge clk); quantum_tick_i = 1'b1;
    @(negedge clk); quantum_tick_i = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk); clr_reqs(); #1;
    check("R1 gnt_last after reset", int'(gnt_last_o), 0);
    check("R2 no request no grant", int'(gnt_valid_o), 0);
    duel("R1 reset rank by thread ID", 5, 2, 1);
    check("R2 grant offered", int'(gnt_valid_o), 1);
  endtask

  task automatic t_cluster();
    // misses per thread 0..7: 10,0,50,5,100,20,1,200; frac 64/256
    // sorted: t1,t6,t3,t0,t5,t2 light (prefix 86 <= 96.5), t4 (h0), t7 (h1) heavy
    int mv[8] = '{10, 0, 50, 5, 100, 20, 1, 200};
    @(negedge clk);
    for (int t = 0; t < 8; t++) miss_cnt_i[t*MISSW +: MISSW] = 16'(mv[t]);
    clus_frac_i = 8'd64;
    shuf_period_i = 16'd1000;
    clr_reqs(); put(0, 0, 0, 1, 10); put(1, 3, 1, 1, 10);
    quantum_tick_i = 1'b1;
    #1 check("R5 old ranks before tick edge", int'(gnt_idx_o), 0);
    @(negedge clk); quantum_tick_i = 1'b0;
    #1 check("R5 new ranks after tick edge", int'(gnt_idx_o), 1);
    duel("R4 lighter light thread wins", 5, 2, 0);
    duel("R4 lighter light thread wins", 2, 6, 1);
    // R3: heavy t4 has open-row hit and max age; light t2 misses and is young
    @(negedge clk);
    clr_reqs();
    open_valid_i = '0; open_valid_i[0] = 1'b1; open_row_i[0 +: ROWW] = 14'h55;
    put(0, 4, 0, 14'h55, 255);
    put(1, 2, 1, 7, 0);
    #1 check("R3 light beats heavy", int'(gnt_idx_o), 1);
    open_valid_i = '0;
    duel("R8 heavy order at offset 0", 7, 4, 1);
  endtask

  task automatic t_shuffle();
    @(negedge clk); shuf_period_i = 16'd20;
    clr_reqs(); put(0, 4, 0, 1, 10); put(1, 7, 1, 1, 10);
    quantum_tick_i = 1'b1;
    @(negedge clk); quantum_tick_i = 1'b0;
    #1 check("R8 offset 0 after tick", int'(gnt_idx_o), 0);
    repeat (19) @(posedge clk);
    @(negedge clk); #1 check("R8 no step before period", int'(gnt_idx_o), 0);
    @(posedge clk);
    @(negedge clk); #1 check("R8 rotated by one", int'(gnt_idx_o), 1);
    repeat (20) @(posedge clk);
    @(negedge clk); #1 check("R8 rotation wraps", int'(gnt_idx_o), 0);
  endtask

  task automatic t_zero();
    @(negedge clk); miss_cnt_i = '0;
    tick();
    duel("R5 zero total all light by ID", 6, 3, 1);
    duel("R5 zero total thread 7 light", 7, 0, 1);
  endtask

  task automatic t_row();
    @(negedge clk);
    clr_reqs();
    open_valid_i = '0; open_valid_i[2] = 1'b1; open_row_i[2*ROWW +: ROWW] = 14'h33;
    put(2, 1, 2, 14'h44, 200);
    put(5, 1, 2, 14'h33, 5);
    #1 check("R6 row hit beats older miss", int'(gnt_idx_o), 5);
    open_valid_i[2] = 1'b0;
    #1 check("R7 closed bank falls back to age", int'(gnt_idx_o), 2);
  endtask

  task automatic t_age();
    @(negedge clk);
    clr_reqs(); open_valid_i = '0;
    put(3, 1, 0, 1, 10); put(7, 1, 1, 2, 30);
    #1 check("R7 oldest wins", int'(gnt_idx_o), 7);
    clr_reqs();
    put(9, 1, 0, 1, 40); put(4, 1, 1, 2, 40);
    #1 check("R7 equal age lower slot", int'(gnt_idx_o), 4);
  endtask

  task automatic t_hand();
    @(negedge clk); clr_reqs(); put(6, 2, 0, 1, 1); gnt_take_i = 1'b1;
    @(negedge clk); gnt_take_i = 1'b0;
    #1 check("R9 capture on take", int'(gnt_last_o), 6);
    clr_reqs(); gnt_take_i = 1'b1;
    @(negedge clk); gnt_take_i = 1'b0;
    #1 check("R9 take without grant holds", int'(gnt_last_o), 6);
    put(11, 2, 0, 1, 1);
    @(negedge clk);
    #1 check("R9 grant without take holds", int'(gnt_last_o), 6);
    clr_reqs();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    t_reset();
    t_cluster();
    t_shuffle();
    t_zero();
    t_row();
    t_age();
    t_hand();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule